// File: doc/BRIEF.md
# Dynamic Segment Approximate Multiplier

This block multiplies two unsigned operands of `N` bits each. It produces an approximate product of `2N` bits and uses only one `M`×`M` multiplier. Each operand passes through a leading-one detector. An `M`-bit window is then taken from that operand, with its top bit at the leading one. The lower bits of the operand fall away. The two windows are multiplied together. The product is shifted left by the total number of bits that were discarded from the two operands.

The block suits datapaths that can accept a small, one-sided error in exchange for a much smaller multiplier. It has one register stage. An operand pair is presented with `valid_i` high, and the result appears one clock later with `valid_o`.

Top module: `dseg_mul`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is 0.
- R2: When both operands are below 2^M, `prod_o` equals the exact product `a*b`.
- R3: When either operand is zero, `prod_o` is 0.
- R4: `prod_o` never exceeds the exact product. The shortfall is at most `a*2^sb + b*2^sa`, where `sa` and `sb` are the shifts of the two operands.
- R5: The result is the product of the two windows, shifted left by `sa+sb`. For an operand whose leading one is at bit position `p`, the window is `x >> s` and the shift is `s = max(0, p-(M-1))`.
- R6: `valid_o` equals `valid_i` from the previous clock edge.
- R7: A cycle in which `valid_i` is low leaves `prod_o` unchanged, whatever the operand inputs carry.
- R8: When both operands are all ones, the result follows R5 with a shift of `N-M` on each side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is valid |
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| valid_o | output | 1 | Result is valid |
| prod_o | output | 2N | Approximate product |

## Verification
The bench builds two copies of the block.

- **Default copy (N=16, M=8).** Here the window covers half the operand. Random operands of varied magnitude exercise shifts from 0 up to 8 per side.
- **Narrow copy (N=10, M=3).** This configuration discards most of the bits, so the truncation error is large. In this copy the R4 shortfall bound is tight rather than trivially met. Almost every operand shape also takes the shifted path.

Both copies get the same stimulus. Zero operands, small operands, all-ones operands and idle cycles with changing inputs are included.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
  // width able to hold a per-operand shift of 0..n-m
  function automatic int unsigned sh_width(int unsigned n, int unsigned m);
    int unsigned w;
    w = $clog2(n - m + 1);
    return (w < 1) ? 1 : w;
  endfunction
  function automatic int unsigned pos_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dseg_lod.sv
module dseg_lod #(
  parameter int unsigned N  = 16,
  parameter int unsigned PW = dseg_pkg::pos_width(N)
) (
  input  logic [N-1:0]  x_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);
  always_comb begin
    pos_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (x_i[i]) begin
        pos_o = PW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dseg_seg.sv
module dseg_seg #(
  parameter int unsigned N  = 16,
  parameter int unsigned M  = 8,
  parameter int unsigned SW = dseg_pkg::sh_width(N, M)
) (
  input  logic [N-1:0]  x_i,
  output logic [M-1:0]  seg_o,
  output logic [SW-1:0] sh_o
);
  localparam int unsigned PW = dseg_pkg::pos_width(N);

  logic [PW-1:0] pos;
  logic          any;
  logic [PW-1:0] sh_full;

  dseg_lod #(.N(N), .PW(PW)) i_lod (
    .x_i  (x_i),
    .pos_o(pos),
    .any_o(any)
  );

  always_comb begin
    if (any && (pos >= PW'(M - 1))) sh_full = pos - PW'(M - 1);
    else                            sh_full = '0;
    sh_o  = SW'(sh_full);
    seg_o = M'(x_i >> sh_o);
  end
endmodule

// File: rtl/dseg_mul.sv
module dseg_mul #(
  parameter int unsigned N = 16,
  parameter int unsigned M = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic           valid_o,
  output logic [2*N-1:0] prod_o
);
  localparam int unsigned SW = dseg_pkg::sh_width(N, M);
  localparam int unsigned TW = SW + 1;

  logic [M-1:0]   seg_a, seg_b;
  logic [SW-1:0]  sh_a, sh_b;
  logic [2*M-1:0] seg_prod;
  logic [TW-1:0]  sh_tot;
  logic [2*N-1:0] prod_d;

  dseg_seg #(.N(N), .M(M), .SW(SW)) i_seg_a (.x_i(a_i), .seg_o(seg_a), .sh_o(sh_a));
  dseg_seg #(.N(N), .M(M), .SW(SW)) i_seg_b (.x_i(b_i), .seg_o(seg_b), .sh_o(sh_b));

  always_comb begin
    seg_prod = seg_a * seg_b;
    sh_tot   = TW'(sh_a) + TW'(sh_b);
    prod_d   = (2*N)'(seg_prod) << sh_tot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/dseg_mul_chk.sv
module dseg_mul_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned M = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic           valid_o,
  input logic [2*N-1:0] prod_o
);
  logic [2*N-1:0] exact;
  logic           small_ops;
  logic           has_zero;
  assign exact     = (2*N)'(a_i) * (2*N)'(b_i);
  assign small_ops = ((a_i >> M) == '0) && ((b_i >> M) == '0);
  assign has_zero  = (a_i == '0) || (b_i == '0);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (!valid_o && prod_o == '0);
    end
  end

  a_r6_valid_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_valid_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o));
  a_r3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && has_zero) |=> (prod_o == '0));
  a_r2_exact_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && small_ops) |=> (prod_o == $past(exact)));
  a_r4_no_overshoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (prod_o <= $past(exact)));
endmodule

bind dseg_mul dseg_mul_chk #(.N(N), .M(M)) i_dseg_mul_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .valid_o(valid_o),
  .prod_o (prod_o)
);

// File: tb/test_dseg_mul.sv
`timescale 1ns/1ps
module test_dseg_mul;
  localparam int N1 = 16, M1 = 8;
  localparam int N2 = 10, M2 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [N1-1:0] a = '0, b = '0;
  logic vo1, vo2;
  logic [2*N1-1:0] p1;
  logic [2*N2-1:0] p2;
  longint unsigned e1 = 0, e2 = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dseg_mul #(.N(N1), .M(M1)) i_dseg_mul (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .valid_o(vo1), .prod_o(p1));
  dseg_mul #(.N(N2), .M(M2)) i_dseg_mul_narrow (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a[N2-1:0]), .b_i(b[N2-1:0]),
    .valid_o(vo2), .prod_o(p2));

  function automatic int shift_of(longint unsigned x, int m);
    int p = -1;
    for (int i = 0; i < 64; i++) if (x[i]) p = i;
    return (p > m - 1) ? p - (m - 1) : 0;
  endfunction

  function automatic longint unsigned model(longint unsigned x, longint unsigned y, int m);
    int sx = shift_of(x, m);
    int sy = shift_of(y, m);
    return ((x >> sx) * (y >> sy)) << (sx + sy);
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bound(string req, longint unsigned x, longint unsigned y, int m,
                       longint unsigned act);
    longint unsigned ex = x * y;
    longint unsigned lim = (x << shift_of(y, m)) + (y << shift_of(x, m));
    checks++;
    if (act > ex || ex - act > lim) begin
      errors++;
      $display("FAIL %s actual=%0d expected_range=[%0d,%0d]", req, act,
               (ex > lim) ? ex - lim : 0, ex);
    end
  endtask

  task automatic step(logic v, logic [N1-1:0] x, logic [N1-1:0] y, string req);
    longint unsigned x2, y2;
    @(negedge clk);
    vld = v; a = x; b = y;
    x2 = longint'(x) & ((64'd1 << N2) - 1);
    y2 = longint'(y) & ((64'd1 << N2) - 1);
    if (v) begin
      e1 = model(x, y, M1);
      e2 = model(x2, y2, M2);
    end
    @(posedge clk); #1;
    chk("R6", vo1, v);
    chk("R6", vo2, v);
    chk(req, p1, e1);
    chk(req, p2, e2);
    if (v) begin
      bound("R4", x, y, M1, p1);
      bound("R4", x2, y2, M2, p2);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", vo1, 0); chk("R1", p1, 0);
    chk("R1", vo2, 0); chk("R1", p2, 0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 16'd0, 16'd1234, "R3");
    step(1, 16'd777, 16'd0, "R3");
    step(1, 16'd200, 16'd255, "R2");
    step(1, 16'd5, 16'd7, "R2");
    step(1, 16'hFFFF, 16'hFFFF, "R8");
    step(1, 16'h8000, 16'h0100, "R5");
    step(1, 16'h1234, 16'h00AB, "R5");
    step(0, 16'hAAAA, 16'h5555, "R7");
    step(0, 16'h0000, 16'h0001, "R7");
    step(1, 16'h03FF, 16'h03FF, "R8");

    for (int i = 0; i < 2000; i++) begin
      logic [N1-1:0] x, y;
      x = N1'($urandom & ((32'd1 << ($urandom % 17)) - 1));
      y = N1'($urandom & ((32'd1 << ($urandom % 17)) - 1));
      step(($urandom % 5) != 0, x, y, "R5");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule